// File: doc/BRIEF.md
# Segmented Effective Address Generator

This unit forms operand addresses for a 16-bit CPU whose memory is reached through 64 KiB segments. From an addressing-mode code, the base pointers (BX, BP), the index pointers (SI, DI) and an instruction displacement, it builds a 16-bit effective address. It then picks the segment, which is the stack segment for any form that uses BP and the data segment otherwise, unless an explicit override is given. It combines that segment with the offset into a 20-bit physical address.

The same unit also resolves I/O port addresses. Port space is 16 bits wide and has no segments. The port number is either an 8-bit immediate from the instruction, which reaches ports 0 to 255, or the full 16-bit DX value. All results are registered once. A single enable qualifies the inputs, and the registered result is marked valid one cycle later.

Top module: `seg_addr_gen`

## Requirements
- R1: With `in_valid` high, mode 0 (direct) and any mode code 5 to 7 give `ea` equal to the effective displacement.
- R2: When `disp_short` is 1, the effective displacement is `disp[7:0]` sign-extended to 16 bits. When it is 0, the effective displacement is `disp` as given.
- R3: Mode 1 (register indirect) gives `ea` from one register chosen by `reg_sel`: 0 selects BX, 1 selects BP, 2 selects SI and 3 selects DI. No displacement is added.
- R4: Mode 2 (based) gives `ea` = base + displacement, where `base_sel` 0 selects BX and 1 selects BP. Mode 3 (indexed) gives `ea` = index + displacement, where `idx_sel` 0 selects SI and 1 selects DI.
- R5: Mode 4 (based-indexed) gives `ea` = base + index + displacement. All four base/index pairings are supported, and every sum wraps modulo 2^16.
- R6: Without an override, any form that reads BP reports `seg_used` = 2 (SS). All other forms report 3 (DS). The segment code map is 0=ES, 1=CS, 2=SS, 3=DS.
- R7: When `ovr_en` is 1 on a memory access, `seg_used` equals `ovr_seg`, and this applies to BP forms as well.
- R8: For a memory access, `is_io` is 0 and `phys` = (segment value × 16 + `ea`) mod 2^20, where the segment value is the register named by `seg_used`.
- R9: With `io_sel` high, `is_io` is 1, `ea` is the port number, `phys` is the port number zero-extended with its top 4 bits at 0, and `seg_used` is 0. The override and mode inputs have no effect.
- R10: An I/O access with `io_indirect` 0 takes the port from `port_imm`, zero-extended. With `io_indirect` 1 it takes the port from `dx`.
- R11: Results appear one clock after the inputs are sampled. `out_valid` is `in_valid` delayed by one cycle, and while `in_valid` is low the outputs `ea`, `seg_used`, `phys` and `is_io` hold their values.
- R12: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs valid; clock enable for the result register |
| mode | input | 3 | Addressing mode code (0 direct, 1 reg-indirect, 2 based, 3 indexed, 4 based-indexed) |
| reg_sel | input | 2 | Register for indirect mode (0 BX, 1 BP, 2 SI, 3 DI) |
| base_sel | input | 1 | Base choice: 0 BX, 1 BP |
| idx_sel | input | 1 | Index choice: 0 SI, 1 DI |
| disp | input | 16 | Instruction displacement |
| disp_short | input | 1 | Sign-extend disp[7:0] |
| ovr_en | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code |
| bx | input | 16 | BX value |
| bp | input | 16 | BP value |
| si | input | 16 | SI value |
| di | input | 16 | DI value |
| dx | input | 16 | DX value for indirect port |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| io_sel | input | 1 | Port access instead of memory |
| io_indirect | input | 1 | Port from DX instead of immediate |
| port_imm | input | 8 | Immediate port number |
| out_valid | output | 1 | Registered result valid |
| ea | output | 16 | Effective address or port number |
| seg_used | output | 2 | Segment code applied |
| phys | output | 20 | Physical address |
| is_io | output | 1 | Result is an I/O port address |

## Verification
The bench targets the places where a wrong default segment is easy to hide. It sends BP in indirect, based and based-indexed forms, both with and without an override, so a design that keyed the segment on the mode, or that let the default win over the override, would report DS where SS or the override is expected. Register and displacement values near 0xFFFF check the wrap of the effective address and of the physical address. Negative short displacements catch a design that zero-extends. On I/O accesses the bench sets an override and BP forms on purpose, so a design that leaks segment logic into the port path would produce nonzero upper physical bits or a wrong `seg_used`. A stall cycle with changed inputs shows whether the outputs follow the inputs when they should hold.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int OFS_W  = 16;
  localparam int SEG_SH = 4;
  localparam int PHY_W  = OFS_W + SEG_SH;
  localparam int NSEG   = 4;

  typedef enum logic [2:0] {
    AM_DIRECT = 3'd0,
    AM_RIND   = 3'd1,
    AM_BASED  = 3'd2,
    AM_INDEX  = 3'd3,
    AM_BIDX   = 3'd4
  } amode_e;

  typedef enum logic [1:0] {
    SG_ES = 2'd0,
    SG_CS = 2'd1,
    SG_SS = 2'd2,
    SG_DS = 2'd3
  } seg_e;
endpackage

// File: rtl/ea_calc.sv
module ea_calc
  import seg_addr_pkg::*;
#(
  parameter int W = OFS_W
) (
  input  logic [2:0]   mode,
  input  logic [1:0]   reg_sel,
  input  logic         base_sel,
  input  logic         idx_sel,
  input  logic [W-1:0] disp,
  input  logic         disp_short,
  input  logic [W-1:0] bx,
  input  logic [W-1:0] bp,
  input  logic [W-1:0] si,
  input  logic [W-1:0] di,
  output logic [W-1:0] ea,
  output logic         uses_bp
);
  logic [W-1:0] disp_x, base_v, idx_v, ind_v;

  always_comb begin
    disp_x = disp_short ? {{(W-8){disp[7]}}, disp[7:0]} : disp;
    base_v = base_sel ? bp : bx;
    idx_v  = idx_sel  ? di : si;
    unique case (reg_sel)
      2'd0:    ind_v = bx;
      2'd1:    ind_v = bp;
      2'd2:    ind_v = si;
      default: ind_v = di;
    endcase
  end

  always_comb begin
    ea      = disp_x;
    uses_bp = 1'b0;
    case (mode)
      AM_RIND:  begin ea = ind_v;                  uses_bp = (reg_sel == 2'd1); end
      AM_BASED: begin ea = base_v + disp_x;        uses_bp = base_sel; end
      AM_INDEX: begin ea = idx_v + disp_x;         uses_bp = 1'b0; end
      AM_BIDX:  begin ea = base_v + idx_v + disp_x; uses_bp = base_sel; end
      default:  begin ea = disp_x;                 uses_bp = 1'b0; end
    endcase
  end
endmodule

// File: rtl/seg_pick.sv
module seg_pick
  import seg_addr_pkg::*;
#(
  parameter int W = OFS_W,
  parameter int N = NSEG
) (
  input  logic                 uses_bp,
  input  logic                 ovr_en,
  input  logic [1:0]           ovr_seg,
  input  logic [N-1:0][W-1:0]  seg_vals,
  output logic [1:0]           seg_code,
  output logic [W-1:0]         seg_base
);
  always_comb begin
    if (ovr_en)       seg_code = ovr_seg;
    else if (uses_bp) seg_code = SG_SS;
    else              seg_code = SG_DS;
    seg_base = seg_vals[seg_code];
  end
endmodule

// File: rtl/phys_form.sv
module phys_form
  import seg_addr_pkg::*;
#(
  parameter int W  = OFS_W,
  parameter int SH = SEG_SH,
  localparam int PW = W + SH
) (
  input  logic [W-1:0]  seg_base,
  input  logic [W-1:0]  ofs,
  input  logic          io_sel,
  output logic [PW-1:0] phys
);
  always_comb begin
    if (io_sel) phys = {{SH{1'b0}}, ofs};
    else        phys = {seg_base, {SH{1'b0}}} + {{SH{1'b0}}, ofs};
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [2:0]  mode,
  input  logic [1:0]  reg_sel,
  input  logic        base_sel,
  input  logic        idx_sel,
  input  logic [15:0] disp,
  input  logic        disp_short,
  input  logic        ovr_en,
  input  logic [1:0]  ovr_seg,
  input  logic [15:0] bx,
  input  logic [15:0] bp,
  input  logic [15:0] si,
  input  logic [15:0] di,
  input  logic [15:0] dx,
  input  logic [15:0] seg_es,
  input  logic [15:0] seg_cs,
  input  logic [15:0] seg_ss,
  input  logic [15:0] seg_ds,
  input  logic        io_sel,
  input  logic        io_indirect,
  input  logic [7:0]  port_imm,
  output logic        out_valid,
  output logic [15:0] ea,
  output logic [1:0]  seg_used,
  output logic [19:0] phys,
  output logic        is_io
);
  localparam int W  = OFS_W;
  localparam int PW = PHY_W;

  logic [W-1:0]           mem_ea, port_v, ofs_d, seg_base;
  logic                   uses_bp;
  logic [1:0]             seg_code, seg_d;
  logic [NSEG-1:0][W-1:0] seg_vals;
  logic [PW-1:0]          phys_d;

  assign seg_vals = {seg_ds, seg_ss, seg_cs, seg_es};

  ea_calc #(.W(W)) u_ea (
    .mode(mode), .reg_sel(reg_sel), .base_sel(base_sel), .idx_sel(idx_sel),
    .disp(disp), .disp_short(disp_short),
    .bx(bx), .bp(bp), .si(si), .di(di),
    .ea(mem_ea), .uses_bp(uses_bp)
  );

  seg_pick #(.W(W), .N(NSEG)) u_seg (
    .uses_bp(uses_bp), .ovr_en(ovr_en), .ovr_seg(ovr_seg),
    .seg_vals(seg_vals), .seg_code(seg_code), .seg_base(seg_base)
  );

  always_comb begin
    port_v = io_indirect ? dx : {{(W-8){1'b0}}, port_imm};
    ofs_d  = io_sel ? port_v : mem_ea;
    seg_d  = io_sel ? SG_ES : seg_code;
  end

  phys_form #(.W(W), .SH(SEG_SH)) u_phys (
    .seg_base(seg_base), .ofs(ofs_d), .io_sel(io_sel), .phys(phys_d)
  );

  // register stage with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ea        <= '0;
      seg_used  <= '0;
      phys      <= '0;
      is_io     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ea       <= ofs_d;
        seg_used <= seg_d;
        phys     <= phys_d;
        is_io    <= io_sel;
      end
    end
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R11
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(phys) && $stable(ea) && $stable(seg_used))); // R11
  AST_IO_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    is_io |-> (phys[19:16] == 4'd0 && phys[15:0] == ea && seg_used == 2'd0)); // R9
  AST_BP_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !io_sel && !ovr_en && mode == 3'd1 && reg_sel == 2'd1) |=> seg_used == 2'd2); // R6
  AST_OVR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !io_sel && ovr_en) |=> seg_used == $past(ovr_seg)); // R7
  AST_DIRECT_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && io_sel && !io_indirect) |=> ea[15:8] == 8'd0); // R10
endmodule

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, in_valid, base_sel, idx_sel, disp_short, ovr_en, io_sel, io_indirect;
  logic [2:0]  mode;
  logic [1:0]  reg_sel, ovr_seg;
  logic [15:0] disp, bx, bp, si, di, dx, seg_es, seg_cs, seg_ss, seg_ds;
  logic [7:0]  port_imm;
  logic        out_valid, is_io;
  logic [15:0] ea;
  logic [1:0]  seg_used;
  logic [19:0] phys;

  int n_chk = 0, n_bad = 0;

  seg_addr_gen u_dut (.*);

  function automatic void model(output logic [15:0] x_ea, output logic [1:0] x_seg,
                                output logic [19:0] x_phys, output logic x_io);
    logic [15:0] d, b, ix, sv;
    logic bpuse;
    d  = disp_short ? {{8{disp[7]}}, disp[7:0]} : disp;
    b  = base_sel ? bp : bx;
    ix = idx_sel ? di : si;
    bpuse = 1'b0;
    case (mode)
      3'd1: begin
        x_ea = (reg_sel == 0) ? bx : (reg_sel == 1) ? bp : (reg_sel == 2) ? si : di;
        bpuse = (reg_sel == 1);
      end
      3'd2: begin x_ea = b + d; bpuse = base_sel; end
      3'd3: x_ea = ix + d;
      3'd4: begin x_ea = b + ix + d; bpuse = base_sel; end
      default: x_ea = d;
    endcase
    x_seg = ovr_en ? ovr_seg : (bpuse ? 2'd2 : 2'd3);
    sv = (x_seg == 0) ? seg_es : (x_seg == 1) ? seg_cs : (x_seg == 2) ? seg_ss : seg_ds;
    x_phys = (20'(sv) << 4) + 20'(x_ea);
    x_io = io_sel;
    if (io_sel) begin
      x_ea   = io_indirect ? dx : {8'd0, port_imm};
      x_seg  = 2'd0;
      x_phys = {4'd0, x_ea};
    end
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, check result at the following negedge
  task automatic apply(input string req);
    logic [15:0] x_ea; logic [1:0] x_seg; logic [19:0] x_phys; logic x_io;
    in_valid = 1'b1;
    model(x_ea, x_seg, x_phys, x_io);
    @(negedge clk);
    chk({req, " ea"},   64'(ea), 64'(x_ea));
    chk({req, " seg"},  64'(seg_used), 64'(x_seg));
    chk({req, " phys"}, 64'(phys), 64'(x_phys));
    chk({req, " io"},   64'(is_io), 64'(x_io));
    chk("R11 valid",    64'(out_valid), 64'd1);
  endtask

  task automatic rnd_all();
    mode = 3'($urandom_range(0, 7)); reg_sel = 2'($urandom); base_sel = 1'($urandom);
    idx_sel = 1'($urandom); disp = 16'($urandom); disp_short = 1'($urandom);
    ovr_en = 1'($urandom); ovr_seg = 2'($urandom);
    bx = 16'($urandom); bp = 16'($urandom); si = 16'($urandom); di = 16'($urandom);
    dx = 16'($urandom); seg_es = 16'($urandom); seg_cs = 16'($urandom);
    seg_ss = 16'($urandom); seg_ds = 16'($urandom);
    io_sel = ($urandom_range(0, 4) == 0); io_indirect = 1'($urandom); port_imm = 8'($urandom);
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = 1'b0;
    rnd_all();
    repeat (3) @(negedge clk);
    chk("R12 valid", 64'(out_valid), 0);
    chk("R12 ea", 64'(ea), 0);
    chk("R12 phys", 64'(phys), 0);
    chk("R12 seg", 64'(seg_used), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 after", 64'(phys), 0);

    // directed corners
    rnd_all(); io_sel = 0; ovr_en = 0;
    mode = 3'd0; disp_short = 0; disp = 16'h1000; apply("R1 direct");
    mode = 3'd6; apply("R1 code6");
    mode = 3'd0; disp_short = 1; disp = 16'h12F0; apply("R2 negext");
    mode = 3'd1; reg_sel = 2'd1; apply("R3 R6 bp ind");
    reg_sel = 2'd3; apply("R3 di ind");
    mode = 3'd2; base_sel = 1; disp_short = 0; disp = 16'hFFFF; bp = 16'h0002; apply("R4 R5 wrap");
    mode = 3'd3; idx_sel = 0; apply("R4 idx");
    for (int p = 0; p < 4; p++) begin
      mode = 3'd4; base_sel = p[1]; idx_sel = p[0]; apply("R5 R6 pair");
    end
    ovr_en = 1; ovr_seg = 2'd0; mode = 3'd4; base_sel = 1; apply("R7 bp ovr");
    ovr_seg = 2'd1; mode = 3'd0; apply("R7 cs ovr");
    ovr_en = 0; seg_ds = 16'hFFFF; mode = 3'd0; disp = 16'hFFFF; disp_short = 0; apply("R8 wrap");
    io_sel = 1; io_indirect = 0; port_imm = 8'hFF; ovr_en = 1; mode = 3'd2; apply("R9 R10 imm");
    io_indirect = 1; dx = 16'hFF55; apply("R9 R10 dx");

    // stall: change inputs, outputs hold
    begin
      logic [19:0] ph; logic [15:0] e;
      ph = phys; e = ea;
      in_valid = 0; io_sel = 0; mode = 3'd0; disp = ~disp;
      @(negedge clk);
      chk("R11 hold phys", 64'(phys), 64'(ph));
      chk("R11 hold ea", 64'(ea), 64'(e));
      chk("R11 valid low", 64'(out_valid), 0);
    end

    for (int i = 0; i < 400; i++) begin
      rnd_all();
      apply("R1 R3 R4 R5 R6 R7 R8 R9 rand");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule